// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Front End

This block is the digital register front end for a four-channel, 8-bit digital-to-analog converter. A host writes to it over a parallel bus that needs no clock: an active-low chip select, an active-low write strobe, a two-bit channel address and an eight-bit data bus. The block brings these signals into its own clock domain through two-flop synchronizers. It stores the data when the combined select-and-write condition ends.

Each channel holds two stages of storage. A bus write fills only the addressed channel's staging register. A separate active-low load input transfers all four staging registers to the output registers together, so that every converter code changes at once. The load input acts as a level: while it is held low, the output registers follow the staging registers on every clock. An asynchronous active-low clear empties both stages. A synchronized power-down flag and a gain-select passthrough go to the analog side along with the four output codes.

Top module: `quad_dac_regif`

## Requirements
- R1: A write is accepted only when `csN` and `wrN` are both low. If either one stays high for the whole strobe, no register changes.
- R2: The channel address `addr` selects channel 0..3 (A..D), with `addr[1]` as the most significant bit. Channel n's output code appears on `dacCode[8n+7:8n]`.
- R3: The data byte is stored without reordering, with `data[7]` as the most significant bit of the stored code.
- R4: A write changes only the addressed channel's staging register. `dacCode` keeps its value while the synchronized load level is inactive.
- R5: While the synchronized load level is active, all four output codes take the staging register contents on the same clock edge.
- R6: A write made while `ldN` is held low reaches `dacCode` one clock after it reaches the staging register, with no further load pulse.
- R7: Driving `clrN` low zeros every staging register and every output register at once, without waiting for a clock edge.
- R8: Clear overrides load. A bus write made while `clrN` is low is discarded.
- R9: `pdFlag` goes high two clocks after `pdN` falls and low two clocks after it rises. Power-down leaves the stored codes untouched, so `dacCode` is the same after power-down is released.
- R10: `gainOut` follows `gainSel` combinationally.
- R11: A write stores the address and data present on the bus at the end of the strobe (the first sample in which `csN` or `wrN` is high again). It takes effect once per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clrN | input | 1 | Asynchronous active-low clear of all registers |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 2 | Channel address, 0..3 selects A..D |
| data | input | 8 | Write data, bit 7 is the MSB |
| ldN | input | 1 | Active-low load level into the output registers |
| pdN | input | 1 | Active-low power-down request |
| gainSel | input | 1 | Range select, 0 = one times, 1 = two times the reference |
| dacCode | output | 32 | Output register codes, channel A in bits 7:0 |
| pdFlag | output | 1 | Synchronized power-down flag, high when powered down |
| gainOut | output | 1 | Gain select passed to the analog side |

## Verification
The assertions assume that `addr` and `data` stay stable from the start of a strobe until a few clocks after it ends. This lets the synchronized bus sample match the value the host meant to write. The power-down property also assumes `pdN` has had three clocks after a clear to settle. The bench drives every input on the falling clock edge. It holds each strobe and each load pulse low for three clocks, keeps the bus steady for five clocks after release, and only changes `pdN` well clear of any clear pulse.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int CH_N   = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(CH_N);
  localparam int CODE_W = CH_N * DATA_W;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              loadLvl;
    logic              pdLvl;
  } dacCtrl_t;
endpackage

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
  import quad_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ldN,
  input  logic              pdN,
  output dacCtrl_t          ctrl
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [SYNC_STAGES-1:0] actSync, ldSync, pdSync;
  logic [BUS_W-1:0]       busSync [SYNC_STAGES];
  logic                   actPrev;

  // Synchronizers reset to the inactive level so that a clear never leaves a pending strobe behind
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      actSync <= '0;
      ldSync  <= '0;
      pdSync  <= '0;
      actPrev <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) busSync[i] <= '0;
    end else begin
      actSync    <= {actSync[SYNC_STAGES-2:0], ~csN & ~wrN};
      ldSync     <= {ldSync[SYNC_STAGES-2:0], ~ldN};
      pdSync     <= {pdSync[SYNC_STAGES-2:0], ~pdN};
      actPrev    <= actSync[SYNC_STAGES-1];
      busSync[0] <= {addr, data};
      for (int i = 1; i < SYNC_STAGES; i++) busSync[i] <= busSync[i-1];
    end
  end

  // A write completes on the cycle the synchronized select-and-write condition goes away
  always_comb begin
    ctrl.wrStb   = actPrev & ~actSync[SYNC_STAGES-1];
    ctrl.wrAddr  = busSync[SYNC_STAGES-1][BUS_W-1:DATA_W];
    ctrl.wrData  = busSync[SYNC_STAGES-1][DATA_W-1:0];
    ctrl.loadLvl = ldSync[SYNC_STAGES-1];
    ctrl.pdLvl   = pdSync[SYNC_STAGES-1];
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import quad_dac_pkg::*;
(
  input  logic              clk,
  input  logic              clrN,
  input  dacCtrl_t          ctrl,
  output logic [CODE_W-1:0] stageFlat,
  output logic [CODE_W-1:0] outFlat
);
  logic [DATA_W-1:0] stageReg [CH_N];
  logic [DATA_W-1:0] outReg   [CH_N];

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        stageReg[ch] <= '0;
        outReg[ch]   <= '0;
      end else begin
        if (ctrl.wrStb && ctrl.wrAddr == ADDR_W'(ch)) stageReg[ch] <= ctrl.wrData;
        if (ctrl.loadLvl) outReg[ch] <= stageReg[ch];
      end
    end

    assign stageFlat[ch*DATA_W +: DATA_W] = stageReg[ch];
    assign outFlat[ch*DATA_W +: DATA_W]   = outReg[ch];
  end
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import quad_dac_pkg::*;
(
  input  logic              clk,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ldN,
  input  logic              pdN,
  input  logic              gainSel,
  output logic [CODE_W-1:0] dacCode,
  output logic              pdFlag,
  output logic              gainOut
);
  dacCtrl_t          ctrl;
  logic [CODE_W-1:0] stageFlat;

  dac_bus_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .addr(addr), .data(data),
    .ldN(ldN), .pdN(pdN), .ctrl(ctrl)
  );

  dac_reg_bank u_bank (
    .clk(clk), .clrN(clrN), .ctrl(ctrl), .stageFlat(stageFlat), .outFlat(dacCode)
  );

  assign pdFlag  = ctrl.pdLvl;
  assign gainOut = gainSel;
endmodule

// File: rtl/quad_dac_regif_checker.sv
module quad_dac_regif_checker
  import quad_dac_pkg::*;
(
  input logic              clk,
  input logic              clrN,
  input logic              pdN,
  input logic              pdFlag,
  input logic [CODE_W-1:0] dacCode,
  input logic [CODE_W-1:0] stageFlat,
  input dacCtrl_t          ctrl
);
  logic [1:0] sinceClr;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) sinceClr <= '0;
    else if (sinceClr != 2'd3) sinceClr <= sinceClr + 2'd1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clrN)
    !ctrl.loadLvl |=> $stable(dacCode));

  assert_load_R5: assert property (@(posedge clk) disable iff (!clrN)
    ctrl.loadLvl |=> dacCode == $past(stageFlat));

  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    assert_only_addressed_R4: assert property (@(posedge clk) disable iff (!clrN)
      !(ctrl.wrStb && ctrl.wrAddr == ADDR_W'(c)) |=> $stable(stageFlat[c*DATA_W +: DATA_W]));
  end

  // Power-down flag trails the pin by the two synchronizer stages (R9)
  assert_pd_latency_R9: assert property (@(posedge clk) disable iff (!clrN)
    (sinceClr == 2'd3) |-> (pdFlag == !$past(pdN, 2)));

  always @(negedge clk) begin
    if (!clrN) begin
      assert_clear_R7: assert (dacCode == '0 && stageFlat == '0);
    end
  end
endmodule

bind quad_dac_regif quad_dac_regif_checker u_chk (
  .clk(clk), .clrN(clrN), .pdN(pdN), .pdFlag(pdFlag),
  .dacCode(dacCode), .stageFlat(stageFlat), .ctrl(ctrl)
);

// File: tb/quad_dac_regif_test.sv
module quad_dac_regif_test;
  logic        clk = 1'b0;
  logic        clrN = 1'b1, csN = 1'b1, wrN = 1'b1, ldN = 1'b1, pdN = 1'b1, gainSel = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [31:0] dacCode;
  logic        pdFlag, gainOut;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  quad_dac_regif uut (
    .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .addr(addr), .data(data),
    .ldN(ldN), .pdN(pdN), .gainSel(gainSel), .dacCode(dacCode), .pdFlag(pdFlag),
    .gainOut(gainOut)
  );

  // {load after write, address, data, expected dacCode}
  localparam logic [42:0] VEC [8] = '{
    {1'b0, 2'd0, 8'h5A, 32'h0000_0000},
    {1'b1, 2'd1, 8'hA3, 32'h0000_A35A},
    {1'b0, 2'd2, 8'h3C, 32'h0000_A35A},
    {1'b1, 2'd3, 8'h81, 32'h813C_A35A},
    {1'b0, 2'd0, 8'hFF, 32'h813C_A35A},
    {1'b1, 2'd0, 8'h01, 32'h813C_A301},
    {1'b1, 2'd2, 8'h80, 32'h8180_A301},
    {1'b0, 2'd1, 8'h7E, 32'h8180_A301}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic c, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; csN = c; wrN = w;
    repeat (3) @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic loadPulse();
    @(negedge clk);
    ldN = 1'b0;
    repeat (3) @(negedge clk);
    ldN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    #5 clrN = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset outputs", dacCode, 32'h0);
    check("R9 reset pdFlag", {31'b0, pdFlag}, 32'h0);
    clrN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R11: table of writes with and without a load
    for (int i = 0; i < 8; i++) begin
      busWrite(1'b0, 1'b0, VEC[i][41:40], VEC[i][39:32]);
      if (VEC[i][42]) loadPulse();
      check("R2/R3/R4/R5/R11 vector", dacCode, VEC[i][31:0]);
    end

    loadPulse();
    check("R5 load without write", dacCode, 32'h8180_7E01);

    // R1: only one of the two strobes low
    busWrite(1'b1, 1'b0, 2'd0, 8'h22);
    busWrite(1'b0, 1'b1, 2'd1, 8'h33);
    loadPulse();
    check("R1 partial strobe ignored", dacCode, 32'h8180_7E01);

    // R6: load held low, write flows through
    @(negedge clk); ldN = 1'b0;
    busWrite(1'b0, 1'b0, 2'd3, 8'h44);
    check("R6 write during load", dacCode, 32'h4480_7E01);
    ldN = 1'b1;
    repeat (4) @(negedge clk);

    busWrite(1'b0, 1'b0, 2'd2, 8'h99);
    check("R4 output holds without load", dacCode, 32'h4480_7E01);

    // R9: power-down latency and preservation
    pdN = 1'b0;
    @(negedge clk);
    check("R9 pdFlag not yet set", {31'b0, pdFlag}, 32'h0);
    @(negedge clk);
    check("R9 pdFlag set after two clocks", {31'b0, pdFlag}, 32'h1);
    check("R9 codes kept in power-down", dacCode, 32'h4480_7E01);
    pdN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 pdFlag released", {31'b0, pdFlag}, 32'h0);
    check("R9 codes restored", dacCode, 32'h4480_7E01);

    // R10
    gainSel = 1'b1; #1;
    check("R10 gain high", {31'b0, gainOut}, 32'h1);
    gainSel = 1'b0; #1;
    check("R10 gain low", {31'b0, gainOut}, 32'h0);

    // R7 R8: asynchronous clear with load asserted and a write attempted
    @(negedge clk); #5;
    ldN = 1'b0; clrN = 1'b0; #1;
    check("R7 async clear", dacCode, 32'h0);
    busWrite(1'b0, 1'b0, 2'd1, 8'h55);
    check("R8 clear beats load", dacCode, 32'h0);
    clrN = 1'b1;
    repeat (4) @(negedge clk);
    ldN = 1'b1;
    repeat (3) @(negedge clk);
    loadPulse();
    check("R8 write during clear discarded", dacCode, 32'h0);

    busWrite(1'b0, 1'b0, 2'd1, 8'h55);
    loadPulse();
    check("R2 channel B after clear", dacCode, 32'h0000_5500);

    done = 1'b1;
    finishRun();
  end
endmodule